// File: doc/BRIEF.md
# GPIO Bank with Latched Pin Interrupts

This block is one bank of general-purpose pins, between 1 and 32 wide, behind a small word-addressed register bus. Each pin can be driven from an output register when its drive-enable bit is set, or read back through a two-flop synchronizer when that bit is clear. Every pin also has an interrupt detector. The detector can watch for an edge or a level, and a separate polarity bit picks rising/high or falling/low. A detected event sets a pending bit. The pending bit holds until software writes a one to it through the clear register.

The bank drives one interrupt request: a registered OR of every pending bit whose enable is set. Software that needs both-edge detection flips a pin's polarity bit after each event. A polarity change on a pin that is not moving creates no event, so this is safe.

Writes take effect on the clock edge on which `wr_en_i` is high. Reads are combinational from `addr_i`. Word addresses: 0 output value, 1 drive enable, 2 synchronized input (read-only), 3 detect mode, 4 polarity, 5 interrupt enable, 6 clear (write-one, reads 0), 7 pending status (read-only).

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, every register (output value, drive enable, mode, polarity, enable, pending) reads 0, `pin_oe_o` is 0 and `irq_o` is 0.
- R2: `pin_out_o` equals the output-value register (address 0), and `pin_oe_o` equals the drive-enable register (address 1), where 1 means the pin is driven and 0 means it is an input.
- R3: Address 2 returns `pin_in_i` through two flops. A change on a pin is not visible one cycle later and is visible two cycles later.
- R4: With mode bit 1 (edge), polarity 1 sets the pending bit on a rising transition of the synchronized pin, and polarity 0 sets it on a falling transition. A transition of the other direction sets nothing.
- R5: With mode bit 0 (level), the pending bit sets while the synchronized pin equals the polarity bit (1 = high, 0 = low). It stays set after the pin leaves that level, until it is cleared.
- R6: Writing 1 to a bit at address 6 clears that pending bit. Writing 0 leaves it unchanged. Address 6 reads as 0.
- R7: If a detection and a clear hit the same bit in the same cycle, the bit stays set.
- R8: In edge mode, changing the polarity bit while the pin is stable never sets the pending bit.
- R9: `irq_o` is a registered OR of (pending AND enable). A pending bit whose enable is 0 still sets but does not raise `irq_o`. `irq_o` falls one cycle after the last enabled pending bit clears.
- R10: The pin count is a parameter. The highest pin of an irregular width detects and clears the same way pin 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register word address |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data of the addressed register |
| pin_in_i | input | NUM_PINS | Pin levels from the pads (asynchronous) |
| pin_out_o | output | NUM_PINS | Value driven on output pins |
| pin_oe_o | output | NUM_PINS | Per-pin drive enable |
| irq_o | output | 1 | Interrupt request to the interrupt controller |

## Verification
The bench builds the bank with NUM_PINS = 27, a width that is neither a power of two nor a full word. This puts the top pin, bit 26, within reach of the edge detect and clear checks. The bench mixes edge and level modes on neighbouring pins within one test, so a mode or polarity bit that leaks onto the wrong pin shows up as an unexpected pending bit. Because the default reset state is level-low detection, the bench must first switch all pins to edge mode and then clear them. This also exercises clearing every bit in a single write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT    = 3'd0,
    REG_OE     = 3'd1,
    REG_IN     = 3'd2,
    REG_MODE   = 3'd3,
    REG_POL    = 3'd4,
    REG_EN     = 3'd5,
    REG_CLR    = 3'd6,
    REG_STATUS = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] mode_i,   // 1 edge, 0 level
  input  logic [WIDTH-1:0] pol_i,    // 1 rising/high, 0 falling/low
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] prev_q, status_q, hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    assign hit[i] = mode_i[i] ? (pol_i[i] ? rise : fall)
                              : (sync_i[i] == pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i]   <= 1'b0;
        status_q[i] <= 1'b0;
      end else begin
        prev_q[i]   <= sync_i[i];
        // new detection outranks a same-cycle clear
        status_q[i] <= (status_q[i] & ~clr_i[i]) | hit[i];
      end
    end
  end

  assign status_o = status_q;

  a_r5_pending_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_q) |=> ((($past(status_q & ~clr_i)) & ~status_q) == '0));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit & clr_i)) |=> ((($past(hit & clr_i)) & ~status_q) == '0));

  a_r8_no_spurious_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(mode_i & ~(sync_i ^ prev_q) & ~status_q))
      |=> ((status_q & $past(mode_i & ~(sync_i ^ prev_q) & ~status_q)) == '0));

  a_r6_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|status_q) |-> $past(|clr_i));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 27
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] out_q, oe_q, mode_q, pol_q, en_q;
  logic [NUM_PINS-1:0] sync_in, status, clr;
  logic                irq_q;
  reg_addr_e           addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oe_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      case (addr)
        REG_OUT:  out_q  <= wdata_i;
        REG_OE:   oe_q   <= wdata_i;
        REG_MODE: mode_q <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_EN:   en_q   <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_en_i && addr == REG_CLR) ? wdata_i : '0;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_in_i),
    .sync_o  (sync_in)
  );

  gpio_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_in),
    .mode_i   (mode_q),
    .pol_i    (pol_q),
    .clr_i    (clr),
    .status_o (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & en_q);
  end

  always_comb begin
    case (addr)
      REG_OUT:    rdata_o = out_q;
      REG_OE:     rdata_o = oe_q;
      REG_IN:     rdata_o = sync_in;
      REG_MODE:   rdata_o = mode_q;
      REG_POL:    rdata_o = pol_q;
      REG_EN:     rdata_o = en_q;
      REG_STATUS: rdata_o = status;
      default:    rdata_o = '0;
    endcase
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = oe_q;
  assign irq_o     = irq_q;

  a_r9_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(status & en_q)));

  a_r9_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(|(status & en_q))) |=> !irq_o);

  a_r2_oe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == REG_OE) |=> (pin_oe_o == $past(wdata_i)));
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int unsigned N = 27;
  localparam logic [N-1:0] ALL = '1;
  localparam logic [N-1:0] TOP = 27'h4000000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    addr_i = 3'd0;
  logic [N-1:0]  wdata_i = '0;
  logic [N-1:0]  rdata_o;
  logic [N-1:0]  pin_in_i = '0;
  logic [N-1:0]  pin_out_o, pin_oe_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_bank #(.NUM_PINS(N)) dut (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pin_in_i, .pin_out_o, .pin_oe_o, .irq_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic pins(logic [N-1:0] v, int cyc);
    @(negedge clk_i);
    pin_in_i = v;
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg", d, '0);
    end
    check("R1 oe", pin_oe_o, '0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_output();
    logic [N-1:0] d;
    wr(3'd0, 27'h5A3C0F1);
    wr(3'd1, 27'h00F0F0F);
    check("R2 out", pin_out_o, 27'h5A3C0F1);
    check("R2 oe", pin_oe_o, 27'h00F0F0F);
    rd(3'd0, d); check("R2 out read", d, 27'h5A3C0F1);
    wr(3'd1, '0);
    check("R2 oe off", pin_oe_o, '0);
  endtask

  task automatic t_input();
    logic [N-1:0] d;
    pins(27'h2B5A5A5, 1);
    rd(3'd2, d); check("R3 one cycle", d, '0);
    @(negedge clk_i);
    rd(3'd2, d); check("R3 two cycles", d, 27'h2B5A5A5);
    pins('0, 4);
    rd(3'd2, d); check("R3 back low", d, '0);
  endtask

  task automatic t_setup_edge();
    logic [N-1:0] d;
    wr(3'd3, ALL);
    wr(3'd6, ALL);
    rd(3'd7, d); check("R6 clear all", d, '0);
  endtask

  task automatic t_pol_stable();
    logic [N-1:0] d;
    wr(3'd4, ALL);
    repeat (4) @(negedge clk_i);
    wr(3'd4, '0);
    repeat (4) @(negedge clk_i);
    rd(3'd7, d); check("R8 polarity flip", d, '0);
  endtask

  task automatic t_edge();
    logic [N-1:0] d;
    wr(3'd4, 27'h1 | TOP);              // bit0, bit26 rising; bit1 falling
    pins(27'h2, 4);                      // bit1 rises: wrong direction
    rd(3'd7, d); check("R4 wrong dir", d, '0);
    pins(27'h1 | TOP, 4);                // bit0/26 rise, bit1 falls
    rd(3'd7, d); check("R4 rise+fall", d, 27'h3 | TOP);
    wr(3'd6, 27'h1);
    rd(3'd7, d); check("R6 clear one", d, 27'h2 | TOP);
    wr(3'd6, '0);
    rd(3'd7, d); check("R6 zero write", d, 27'h2 | TOP);
    rd(3'd6, d); check("R6 reads zero", d, '0);
    wr(3'd6, TOP);
    rd(3'd7, d); check("R10 top pin clear", d, 27'h2);
    wr(3'd6, 27'h2);
    pins('0, 4);                         // bit0 falls, rising pol: nothing
    rd(3'd7, d); check("R4 fall ignored", d, '0);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(3'd3, ALL & ~27'h4);              // bit2 level
    wr(3'd4, 27'h4);                     // high
    wr(3'd6, ALL);
    rd(3'd7, d); check("R5 idle", d, '0);
    pins(27'h4, 4);
    rd(3'd7, d); check("R5 high sets", d, 27'h4);
    pins('0, 4);
    rd(3'd7, d); check("R5 latched", d, 27'h4);
    wr(3'd6, 27'h4);
    rd(3'd7, d); check("R5 cleared", d, '0);
  endtask

  task automatic t_collide();
    logic [N-1:0] d;
    pins(27'h4, 4);
    wr(3'd6, 27'h4);                     // level still true
    rd(3'd7, d); check("R7 set wins", d, 27'h4);
    pins('0, 4);
    wr(3'd6, 27'h4);
    rd(3'd7, d); check("R7 clear after", d, '0);
  endtask

  task automatic t_irq();
    logic [N-1:0] d;
    wr(3'd5, 27'h4);
    check("R9 idle", irq_o, 0);
    pins(27'h4, 5);
    check("R9 raised", irq_o, 1);
    pins('0, 3);
    wr(3'd6, 27'h4);
    check("R9 one cycle late", irq_o, 1);
    @(negedge clk_i);
    check("R9 dropped", irq_o, 0);
    wr(3'd5, '0);
    pins(27'h4, 5);
    rd(3'd7, d); check("R9 masked pending", d, 27'h4);
    check("R9 masked irq", irq_o, 0);
    wr(3'd5, 27'h4);
    @(negedge clk_i);
    check("R9 unmask", irq_o, 1);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_output();
    t_input();
    t_setup_edge();
    t_pol_stable();
    t_edge();
    t_level();
    t_collide();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule